// File: doc/BRIEF.md
# Multi-Source Reset Generation Unit

This unit collects every request for a reset and drives two separate reset outputs. One output resets the main system domain. The other resets the battery-backed clock domain. The system reset has two kinds of source. The first is a completed entry into one of three low-power modes (standby, stop, shutdown) when the option bit for that mode is cleared. The second is a software launch of an option reload. The backup-domain reset also has two kinds of source. The first is a software control bit. The second is the return of supply after both the main and the battery supply had been lost.

Each low-power mode has an active-low option input. When the bit is set, a completed entry is accepted and the unit pulses a grant output for that mode. When the bit is cleared, the unit does not grant the mode and issues a system reset in its place. Every reset output lasts at least 16 clock cycles. A sticky cause register records which sources produced system resets. Software clears it with a one-cycle clear strobe. The backup-domain reset never touches the system reset or the cause register.

The asynchronous active-low input `rst_n` is the always-on power-on reset. Its release is synchronized inside the unit, so the unit starts working two clock cycles after `rst_n` goes high.

Top module: `rgu_reset_unit`

## Requirements
- R1: After reset release, `sys_rst_o`, `bkp_rst_o`, `mode_grant_o` and `cause_o` are all zero, and the supply tracker has not armed a power-on backup reset.
- R2: Mode index 0 is standby, 1 is stop and 2 is shutdown. A one-cycle `mode_done_i[k]` with `mode_keep_i[k]`=1 makes `mode_grant_o[k]` high for exactly the next cycle. It produces no system reset and does not change `cause_o`.
- R3: A one-cycle `mode_done_i[k]` with `mode_keep_i[k]`=0 gives no grant. It makes `sys_rst_o` high from the next cycle for exactly MIN_LEN (16) cycles.
- R4: While `sys_rst_o` is high, mode completion strobes are ignored. They give no grant, do not lengthen the reset and set no cause bit.
- R5: A rising edge of `optload_go_i` makes `sys_rst_o` high from the next cycle for 16 cycles. Holding the bit high does not start a further reset, and a falling edge starts none.
- R6: `cause_o` bit 0 records standby, bit 1 stop, bit 2 shutdown and bit 3 option reload. Each bit is set by its system-reset source and stays set until a `cause_clr_i` strobe. If a clear and a new source arrive in the same cycle, the new source's bit ends up set.
- R7: `bkp_rst_o` is high from the cycle after `bkp_sw_rst_i` rises, for as long as the bit stays high, and for 15 more cycles after it falls. That is H+15 cycles for H sampled high cycles. `sys_rst_o` and `cause_o` are not affected.
- R8: When both `main_pwr_ok_i` and `batt_pwr_ok_i` are low, a flag is armed. The first cycle either supply is back, `bkp_rst_o` is issued for 16 cycles and the flag clears. Losing only one supply issues no backup reset.
- R9: A new rising edge of `optload_go_i` while `sys_rst_o` is high restarts the 16-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Always-on power-on reset, asynchronous, active low |
| mode_done_i | input | 3 | Mode entry completed strobes (0 standby, 1 stop, 2 shutdown) |
| mode_keep_i | input | 3 | Option bits, active low reset substitution (1 = grant mode) |
| optload_go_i | input | 1 | Software option reload launch bit |
| bkp_sw_rst_i | input | 1 | Software backup-domain reset bit, level sensitive |
| main_pwr_ok_i | input | 1 | Main supply present |
| batt_pwr_ok_i | input | 1 | Battery supply present |
| cause_clr_i | input | 1 | Write-one strobe clearing the cause register |
| sys_rst_o | output | 1 | System domain reset, active high |
| bkp_rst_o | output | 1 | Backup domain reset, active high |
| mode_grant_o | output | 3 | One-cycle grant per low-power mode |
| cause_o | output | 4 | Sticky system-reset cause bits |

## Verification
The assertions assume three things about the inputs. At most one mode completion strobe is high in any cycle. Each strobe lasts a single cycle. The option bits are steady while a strobe is presented. The directed stimulus follows these rules: it raises one mode strobe for exactly one cycle, and it sets the option bits at least a cycle before the strobe. The stretch-length checks count high cycles in the checker instead of using deep history. This lets them accept the longer backup reset that a held software bit produces.

// File: rtl/rgu_pkg.sv
package rgu_pkg;
  localparam int unsigned NMODE     = 3;
  localparam int unsigned MODE_STBY = 0;
  localparam int unsigned MODE_STOP = 1;
  localparam int unsigned MODE_SHDN = 2;
  localparam int unsigned CAUSE_OPT = NMODE;
  localparam int unsigned CAUSE_W   = NMODE + 1;

  typedef enum logic {
    SUP_LIVE = 1'b0,
    SUP_DARK = 1'b1
  } sup_state_e;
endpackage

// File: rtl/rgu_rst_sync.sv
module rgu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rgu_stretch.sv
module rgu_stretch #(
  parameter int unsigned MIN_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(MIN_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(MIN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (trig_i) begin
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rgu_mode_ctl.sv
module rgu_mode_ctl #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] keep_i,
  input  logic         block_i,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] rst_req_o
);
  for (genvar m = 0; m < N; m++) begin : g_mode
    logic take;
    logic grant_d, grant_q;

    // A completed entry counts only while the system is out of reset
    assign take         = done_i[m] & ~block_i;
    assign rst_req_o[m] = take & ~keep_i[m];
    assign grant_d      = take & keep_i[m];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_q <= 1'b0;
      else        grant_q <= grant_d;
    end

    assign grant_o[m] = grant_q;
  end
endmodule

// File: rtl/rgu_supply_trk.sv
module rgu_supply_trk
  import rgu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic main_ok_i,
  input  logic batt_ok_i,
  output logic por_o
);
  sup_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    por_o    = 1'b0;
    unique case (state_q)
      SUP_LIVE: begin
        if (!main_ok_i && !batt_ok_i) begin
          state_d  = SUP_DARK;
          state_en = 1'b1;
        end
      end
      SUP_DARK: begin
        if (main_ok_i || batt_ok_i) begin
          por_o    = 1'b1;
          state_d  = SUP_LIVE;
          state_en = 1'b1;
        end
      end
      default: begin
        state_d  = SUP_LIVE;
        state_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= SUP_LIVE;
    else if (state_en) state_q <= state_d;
  end
endmodule

// File: rtl/rgu_cause_reg.sv
module rgu_cause_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q, cause_d;
  logic         cause_en;

  always_comb begin
    cause_en = clr_i | (|set_i);
    cause_d  = (clr_i ? '0 : cause_q) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rgu_reset_unit.sv
module rgu_reset_unit
  import rgu_pkg::*;
#(
  parameter int unsigned MIN_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NMODE-1:0]   mode_done_i,
  input  logic [NMODE-1:0]   mode_keep_i,
  input  logic               optload_go_i,
  input  logic               bkp_sw_rst_i,
  input  logic               main_pwr_ok_i,
  input  logic               batt_pwr_ok_i,
  input  logic               cause_clr_i,
  output logic               sys_rst_o,
  output logic               bkp_rst_o,
  output logic [NMODE-1:0]   mode_grant_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               rst_sync_n;
  logic [NMODE-1:0]   mode_rst_req;
  logic               opt_prev_q;
  logic               opt_edge;
  logic               sys_trig;
  logic               bkp_trig;
  logic               por_trig;
  logic [CAUSE_W-1:0] cause_set;

  rgu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rgu_mode_ctl #(.N(NMODE)) u_mode_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .done_i    (mode_done_i),
    .keep_i    (mode_keep_i),
    .block_i   (sys_rst_o),
    .grant_o   (mode_grant_o),
    .rst_req_o (mode_rst_req)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) opt_prev_q <= 1'b0;
    else             opt_prev_q <= optload_go_i;
  end

  assign opt_edge  = optload_go_i & ~opt_prev_q;
  assign sys_trig  = (|mode_rst_req) | opt_edge;
  assign cause_set = {opt_edge, mode_rst_req};

  rgu_stretch #(.MIN_LEN(MIN_LEN)) u_sys_stretch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig_i   (sys_trig),
    .active_o (sys_rst_o)
  );

  rgu_cause_reg #(.W(CAUSE_W)) u_cause (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (cause_set),
    .clr_i   (cause_clr_i),
    .cause_o (cause_o)
  );

  rgu_supply_trk u_supply (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .main_ok_i (main_pwr_ok_i),
    .batt_ok_i (batt_pwr_ok_i),
    .por_o     (por_trig)
  );

  assign bkp_trig = bkp_sw_rst_i | por_trig;

  rgu_stretch #(.MIN_LEN(MIN_LEN)) u_bkp_stretch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig_i   (bkp_trig),
    .active_o (bkp_rst_o)
  );
endmodule

// File: rtl/rgu_reset_unit_chk.sv
module rgu_reset_unit_chk
  import rgu_pkg::*;
#(
  parameter int unsigned MIN_LEN = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NMODE-1:0]   mode_done_i,
  input logic [NMODE-1:0]   mode_keep_i,
  input logic               optload_go_i,
  input logic               bkp_sw_rst_i,
  input logic               cause_clr_i,
  input logic               sys_rst_o,
  input logic               bkp_rst_o,
  input logic [NMODE-1:0]   mode_grant_o,
  input logic [CAUSE_W-1:0] cause_o
);
  logic [31:0] sys_run_q, bkp_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_run_q <= '0;
      bkp_run_q <= '0;
    end else begin
      sys_run_q <= sys_rst_o ? ((sys_run_q == 32'hFFFF_FFFF) ? sys_run_q : sys_run_q + 1) : '0;
      bkp_run_q <= bkp_rst_o ? ((bkp_run_q == 32'hFFFF_FFFF) ? bkp_run_q : bkp_run_q + 1) : '0;
    end
  end

  // R2: at most one grant at a time (one mode strobe per cycle assumed)
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_grant_o));

  for (genvar k = 0; k < NMODE; k++) begin : g_chk
    // R2: a grant follows an accepted completion with the option bit set
    a_r2_grant_source: assert property (@(posedge clk) disable iff (!rst_n)
      mode_grant_o[k] |-> $past(mode_done_i[k] && mode_keep_i[k] && !sys_rst_o));
    // R3: completion with cleared option bit starts a system reset
    a_r3_mode_to_rst: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_done_i[k] && !mode_keep_i[k] && !sys_rst_o) |=> sys_rst_o);
    // R6: a cause bit drops only on a clear strobe
    a_r6_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cause_o[k]) |-> $past(cause_clr_i));
  end

  // R3: system reset lasts at least MIN_LEN cycles
  a_r3_sys_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (sys_run_q >= MIN_LEN));

  // R4: no grant in the cycle after the system reset was active
  a_r4_no_grant_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sys_rst_o) |-> (mode_grant_o == '0));

  // R5: rising edge of the reload bit starts a system reset
  a_r5_optload_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (optload_go_i && !$past(optload_go_i)) |=> sys_rst_o);

  // R6: option-reload cause bit set only by the reload bit
  a_r6_opt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_o[CAUSE_OPT]) |-> $past(optload_go_i));

  // R7: software backup bit drives the backup reset
  a_r7_bkp_sw: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_sw_rst_i |=> bkp_rst_o);

  // R8: backup reset lasts at least MIN_LEN cycles
  a_r8_bkp_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bkp_rst_o) |-> (bkp_run_q >= MIN_LEN));
endmodule

bind rgu_reset_unit rgu_reset_unit_chk #(.MIN_LEN(MIN_LEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mode_done_i  (mode_done_i),
  .mode_keep_i  (mode_keep_i),
  .optload_go_i (optload_go_i),
  .bkp_sw_rst_i (bkp_sw_rst_i),
  .cause_clr_i  (cause_clr_i),
  .sys_rst_o    (sys_rst_o),
  .bkp_rst_o    (bkp_rst_o),
  .mode_grant_o (mode_grant_o),
  .cause_o      (cause_o)
);

// File: tb/rgu_reset_unit_tb.sv
module rgu_reset_unit_tb;
  import rgu_pkg::*;

  localparam int MIN_LEN = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic [NMODE-1:0]   mode_done_i, mode_keep_i, mode_grant_o;
  logic               optload_go_i, bkp_sw_rst_i, main_pwr_ok_i, batt_pwr_ok_i, cause_clr_i;
  logic               sys_rst_o, bkp_rst_o;
  logic [CAUSE_W-1:0] cause_o;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  rgu_reset_unit #(.MIN_LEN(MIN_LEN)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_done_i   (mode_done_i),
    .mode_keep_i   (mode_keep_i),
    .optload_go_i  (optload_go_i),
    .bkp_sw_rst_i  (bkp_sw_rst_i),
    .main_pwr_ok_i (main_pwr_ok_i),
    .batt_pwr_ok_i (batt_pwr_ok_i),
    .cause_clr_i   (cause_clr_i),
    .sys_rst_o     (sys_rst_o),
    .bkp_rst_o     (bkp_rst_o),
    .mode_grant_o  (mode_grant_o),
    .cause_o       (cause_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count consecutive sampled high cycles of sys_rst_o from the current negedge
  task automatic sys_len(output int n);
    n = 0;
    while (sys_rst_o && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_cause();
    @(negedge clk) cause_clr_i = 1'b1;
    @(negedge clk) cause_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mode_done_i = '0; mode_keep_i = '1;
    optload_go_i = 1'b0; bkp_sw_rst_i = 1'b0; cause_clr_i = 1'b0;
    main_pwr_ok_i = 1'b1; batt_pwr_ok_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sys_rst", int'(sys_rst_o), 0);
    chk("R1 bkp_rst", int'(bkp_rst_o), 0);
    chk("R1 grant", int'(mode_grant_o), 0);
    chk("R1 cause", int'(cause_o), 0);
    repeat (20) @(negedge clk);
    chk("R1 no armed backup reset", int'(bkp_rst_o), 0);
  endtask

  task automatic t_grant(input int k);
    mode_keep_i = '1;
    @(negedge clk) mode_done_i = NMODE'(1 << k);
    @(negedge clk) mode_done_i = '0;
    chk($sformatf("R2 grant mode %0d", k), int'(mode_grant_o), 1 << k);
    chk($sformatf("R2 no reset mode %0d", k), int'(sys_rst_o), 0);
    @(negedge clk);
    chk($sformatf("R2 grant one cycle mode %0d", k), int'(mode_grant_o), 0);
    chk($sformatf("R2 cause untouched mode %0d", k), int'(cause_o), 0);
  endtask

  task automatic t_mode_rst(input int k);
    int n;
    mode_keep_i = ~NMODE'(1 << k);
    @(negedge clk) mode_done_i = NMODE'(1 << k);
    @(negedge clk) mode_done_i = '0;
    chk($sformatf("R3 no grant mode %0d", k), int'(mode_grant_o), 0);
    sys_len(n);
    chk($sformatf("R3 reset length mode %0d", k), n, MIN_LEN);
    chk($sformatf("R6 cause bit mode %0d", k), int'(cause_o), 1 << k);
    clear_cause();
    chk("R6 cause cleared", int'(cause_o), 0);
    mode_keep_i = '1;
  endtask

  task automatic t_ignore();
    int n;
    int gseen;
    mode_keep_i = 3'b101;
    @(negedge clk) mode_done_i = 3'b010;
    @(negedge clk) mode_done_i = 3'b000;
    n = 0; gseen = 0;
    while (sys_rst_o && n < 2000) begin
      n++;
      if (mode_grant_o != '0) gseen++;
      if (n == 4) mode_done_i = 3'b001;
      if (n == 5) mode_done_i = 3'b000;
      if (n == 8) mode_done_i = 3'b010;
      if (n == 9) mode_done_i = 3'b000;
      @(negedge clk);
    end
    if (mode_grant_o != '0) gseen++;
    chk("R4 reset not lengthened", n, MIN_LEN);
    chk("R4 no grant during reset", gseen, 0);
    chk("R4 only stop cause", int'(cause_o), 2);
    clear_cause();
    mode_keep_i = '1;
  endtask

  task automatic t_optload();
    int n;
    int extra;
    @(negedge clk) optload_go_i = 1'b1;
    @(negedge clk);
    sys_len(n);
    chk("R5 reload reset length", n, MIN_LEN);
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      if (sys_rst_o) extra++;
      @(negedge clk);
    end
    chk("R5 held bit no new reset", extra, 0);
    chk("R6 reload cause bit", int'(cause_o), 8);
    optload_go_i = 1'b0;
    extra = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (sys_rst_o) extra++;
    end
    chk("R5 falling edge no reset", extra, 0);
    // clear together with a fresh trigger: trigger wins
    @(negedge clk) begin optload_go_i = 1'b1; cause_clr_i = 1'b1; end
    @(negedge clk) cause_clr_i = 1'b0;
    sys_len(n);
    chk("R6 set beats clear", int'(cause_o), 8);
    optload_go_i = 1'b0;
    clear_cause();
  endtask

  task automatic t_retrig();
    int n;
    @(negedge clk) optload_go_i = 1'b1;
    @(negedge clk);
    n = 0;
    while (sys_rst_o && n < 2000) begin
      n++;
      if (n == 5) optload_go_i = 1'b0;
      if (n == 6) optload_go_i = 1'b1;
      @(negedge clk);
    end
    chk("R9 restart length", n, 6 + MIN_LEN);
    optload_go_i = 1'b0;
    clear_cause();
  endtask

  task automatic t_bkp_sw();
    int n;
    int sh;
    @(negedge clk) bkp_sw_rst_i = 1'b1;
    n = 0; sh = 0;
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (i == 30) bkp_sw_rst_i = 1'b0;
      if (bkp_rst_o) n++;
      if (sys_rst_o) sh++;
    end
    chk("R7 backup length held", n, 30 + MIN_LEN - 1);
    chk("R7 system reset untouched", sh, 0);
    chk("R7 cause untouched", int'(cause_o), 0);
  endtask

  task automatic t_supply();
    int n;
    int sh;
    // main supply alone lost
    @(negedge clk) main_pwr_ok_i = 1'b0;
    n = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (i == 6) main_pwr_ok_i = 1'b1;
      if (bkp_rst_o) n++;
    end
    chk("R8 single supply loss", n, 0);
    // both lost, then battery returns
    @(negedge clk) begin main_pwr_ok_i = 1'b0; batt_pwr_ok_i = 1'b0; end
    n = 0; sh = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (bkp_rst_o) n++;
    end
    chk("R8 no reset while dark", n, 0);
    batt_pwr_ok_i = 1'b1;
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 1) chk("R8 reset starts next cycle", int'(bkp_rst_o), 1);
      if (bkp_rst_o) n++;
      if (sys_rst_o) sh++;
    end
    chk("R8 power-on backup length", n, MIN_LEN);
    chk("R8 system reset untouched", sh, 0);
    // flag cleared: a main-only dip and return does nothing
    @(negedge clk) main_pwr_ok_i = 1'b0;
    n = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (i == 5) main_pwr_ok_i = 1'b1;
      if (bkp_rst_o) n++;
    end
    chk("R8 flag cleared after issue", n, 0);
  endtask

  initial begin
    t_reset();
    for (int k = 0; k < NMODE; k++) t_grant(k);
    for (int k = 0; k < NMODE; k++) t_mode_rst(k);
    t_ignore();
    t_grant(MODE_STBY);
    t_optload();
    t_retrig();
    t_bkp_sw();
    t_supply();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule